// File: doc/BRIEF.md
# Split-Register Performance Counter Unit

This block counts processor activity for profiling. It holds one free-running cycle counter and four event counters, all 32 bits wide. Each event counter watches one line of a wide strobe vector. The line is picked by an 8-bit event code, and the reserved code 0xFF stops that counter. A global enable gates all counting. The cycle counter can instead advance once per 64 enabled clocks, so that long intervals fit in 32 bits.

Configuration is split across dedicated registers on a simple word-addressed write/read bus. These are a control register, a sticky overflow-flag register, an interrupt-enable register and a packed event-select register. The flag and enable registers use the same map: bit 0 is the cycle counter and bits 1 to 4 are event counters 0 to 3. Every counter also has its own address, where it can be read or loaded. When a counter wraps, it raises its flag. The single interrupt line is high while any flag is set together with its enable bit.

Word addresses: 0 control, 1 overflow flags, 2 interrupt enable, 3 event select, 4 cycle counter, 5 to 8 event counters 0 to 3. Writes take effect at the clock edge where `reg_wr` is high. Read data is combinational from `reg_addr`.

Top module: `perf_counter_unit`

## Requirements
- R1: After reset, all counters, the flags, the interrupt enables and the event-select register read 0, and `irq` is low. The control register reads with only its identity field, bits 31:24, non-zero.
- R2: In the control register, bit 0 (enable) and bit 3 (divide by 64) are stored and read back. Bits 31:24 always read the identity parameter. Bits 23:4 and 2:1 read 0 whatever was written.
- R3: While enabled and not dividing, the cycle counter rises by 1 at every clock edge. While disabled, it holds its value.
- R4: With divide-by-64 set, the cycle counter advances once per 64 enabled edges, counted from a cycle-counter reset.
- R5: Event counter i rises by 1 at each enabled edge where `ev_strobe[code_i]` is high. Its code sits in event-select bits 8i+7:8i.
- R6: A counter whose code is 0xFF never counts, even when strobe line 255 is high.
- R7: A write to a counter address loads that counter. A load takes precedence over an increment in the same cycle.
- R8: A control write with bit 1 set clears all four event counters. A control write with bit 2 set clears the cycle counter and its divider. Neither clears the other group.
- R9: A counter wrapping from all ones to zero sets its flag: bit 0 for the cycle counter, bit 1+i for event counter i. Writing 1 to a flag bit clears it, and writing 0 leaves it unchanged.
- R10: A flag being set by a wrap takes precedence over a clear written in the same cycle.
- R11: `irq` is high exactly when some flag bit and the same interrupt-enable bit are both 1. The interrupt-enable register stores only bits 4:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Write strobe for the register bus |
| reg_addr | input | 4 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| ev_strobe | input | 256 | Event pulses, one line per event code |
| irq | output | 1 | Overflow interrupt |

## Verification
The cycle counter is run for a run length that ends one edge before a divider boundary and for one that ends exactly on it. This separates a correct divide-by-64 from an off-by-one prescaler. For the event counters, each counter is driven with a different number of strobe cycles on a different code. A wrong field position or a swapped counter therefore shows up as a wrong count. Strobing line 255 together with line 0 shows whether a parked counter is counting. Wraps are timed to land on the same edge as a load or as a flag clear, to test which side wins.

// File: rtl/perf_counter_unit.sv
module perf_counter_unit #(
  parameter int          DATA_W  = 32,
  parameter int          NUM_EV  = 4,
  parameter int          EV_W    = 8,
  parameter int          ADDR_W  = 4,
  parameter int          DIV_W   = 6,
  parameter logic [7:0]  CHIP_ID = 8'h5A
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reg_wr,
  input  logic [ADDR_W-1:0]     reg_addr,
  input  logic [DATA_W-1:0]     reg_wdata,
  output logic [DATA_W-1:0]     reg_rdata,
  input  logic [(1<<EV_W)-1:0]  ev_strobe,
  output logic                  irq
);
  localparam int FLG_W = NUM_EV + 1;
  localparam int SEL_W = EV_W * NUM_EV;
  localparam logic [EV_W-1:0]   PARK   = '1;
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_FLAG = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_IEN  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_ESEL = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_CYC  = ADDR_W'(4);
  localparam int                A_EV0  = 5;

  logic              ctl_en, ctl_div;
  logic [DIV_W-1:0]  prescale;
  logic [DATA_W-1:0] cyc_cnt;
  logic [DATA_W-1:0] ev_cnt [NUM_EV];
  logic [FLG_W-1:0]  ovf_flags, int_en, ovf_set;
  logic [SEL_W-1:0]  ev_sel;

  wire ctl_wr  = reg_wr && reg_addr == A_CTRL;
  wire ev_clr  = ctl_wr && reg_wdata[1];
  wire cyc_clr = ctl_wr && reg_wdata[2];
  wire cyc_ld  = reg_wr && reg_addr == A_CYC;
  wire cyc_inc = ctl_en && (!ctl_div || &prescale);

  assign ovf_set[0] = cyc_inc && &cyc_cnt && !cyc_ld && !cyc_clr;
  assign irq = |(ovf_flags & int_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_en  <= 1'b0;
      ctl_div <= 1'b0;
      int_en  <= '0;
      ev_sel  <= '0;
    end else if (reg_wr) begin
      if (reg_addr == A_CTRL) begin
        ctl_en  <= reg_wdata[0];
        ctl_div <= reg_wdata[3];
      end
      if (reg_addr == A_IEN)  int_en <= reg_wdata[FLG_W-1:0];
      if (reg_addr == A_ESEL) ev_sel <= reg_wdata[SEL_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prescale <= '0;
      cyc_cnt  <= '0;
    end else begin
      if (cyc_clr) prescale <= '0;
      else if (ctl_en && ctl_div) prescale <= prescale + 1'b1;
      if (cyc_ld) cyc_cnt <= reg_wdata;
      else if (cyc_clr) cyc_cnt <= '0;
      else if (cyc_inc) cyc_cnt <= cyc_cnt + 1'b1;
    end
  end

  for (genvar i = 0; i < NUM_EV; i++) begin : g_ev
    wire [EV_W-1:0] code = ev_sel[i*EV_W +: EV_W];
    wire ld  = reg_wr && reg_addr == ADDR_W'(A_EV0 + i);
    wire inc = ctl_en && code != PARK && ev_strobe[code];
    assign ovf_set[i+1] = inc && &ev_cnt[i] && !ld && !ev_clr;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ev_cnt[i] <= '0;
      else if (ld)     ev_cnt[i] <= reg_wdata;
      else if (ev_clr) ev_cnt[i] <= '0;
      else if (inc)    ev_cnt[i] <= ev_cnt[i] + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovf_flags <= '0;
    else if (reg_wr && reg_addr == A_FLAG)
      ovf_flags <= (ovf_flags & ~reg_wdata[FLG_W-1:0]) | ovf_set;
    else
      ovf_flags <= ovf_flags | ovf_set;
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL: begin
        reg_rdata[DATA_W-1 -: 8] = CHIP_ID;
        reg_rdata[3] = ctl_div;
        reg_rdata[0] = ctl_en;
      end
      A_FLAG: reg_rdata = DATA_W'(ovf_flags);
      A_IEN:  reg_rdata = DATA_W'(int_en);
      A_ESEL: reg_rdata = DATA_W'(ev_sel);
      A_CYC:  reg_rdata = cyc_cnt;
      default: begin
        for (int i = 0; i < NUM_EV; i++)
          if (reg_addr == ADDR_W'(A_EV0 + i)) reg_rdata = ev_cnt[i];
      end
    endcase
  end
endmodule

// File: rtl/perf_counter_chk.sv
module perf_counter_chk #(
  parameter int         DATA_W  = 32,
  parameter int         NUM_EV  = 4,
  parameter int         ADDR_W  = 4,
  parameter logic [7:0] CHIP_ID = 8'h5A
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_rdata,
  input logic              irq,
  input logic              ctl_en,
  input logic              ctl_div,
  input logic [DATA_W-1:0] cyc_cnt,
  input logic [NUM_EV:0]   ovf_flags,
  input logic [NUM_EV:0]   int_en
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_FLAG = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_CYC  = ADDR_W'(4);

  wire cyc_touch = reg_wr && (reg_addr == A_CYC || reg_addr == A_CTRL);

  AST_CTRL_RSVD: assert property (@(posedge clk) disable iff (!rst_n)
    reg_addr == A_CTRL |-> reg_rdata[DATA_W-1 -: 8] == CHIP_ID && reg_rdata[DATA_W-9:4] == '0 && reg_rdata[2:1] == 2'b00); // R2
  AST_CYC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_en && !cyc_touch |=> $stable(cyc_cnt)); // R3
  AST_CYC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_en && !ctl_div && !cyc_touch |=> cyc_cnt == $past(cyc_cnt) + 1'b1); // R3
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_addr == A_FLAG) |=> (ovf_flags & $past(ovf_flags)) == $past(ovf_flags)); // R9
  AST_WRAP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_en && !ctl_div && &cyc_cnt && !cyc_touch |=> ovf_flags[0]); // R10
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    int_en == '0 |-> !irq); // R11
endmodule

bind perf_counter_unit perf_counter_chk #(
  .DATA_W(DATA_W), .NUM_EV(NUM_EV), .ADDR_W(ADDR_W), .CHIP_ID(CHIP_ID)
) u_chk (.*);

// File: tb/sim_perf_counter_unit.sv
module sim_perf_counter_unit;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         reg_wr = 1'b0;
  logic [3:0]   reg_addr = '0;
  logic [31:0]  reg_wdata = '0;
  logic [31:0]  reg_rdata;
  logic [255:0] ev_strobe = '0;
  logic         irq;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  localparam logic [7:0] ID = 8'h5A;

  perf_counter_unit u0 (.*);

  always #4 clk = ~clk;

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #2;
    reg_wr = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(0, v); chk("R1 ctrl", v, {ID, 24'h0});
    for (int a = 1; a <= 8; a++) begin rd(4'(a), v); chk("R1 reg", v, 0); end
    chk("R1 irq", 32'(irq), 0);
  endtask

  task automatic t_ctrl;
    logic [31:0] v;
    wr(0, 32'hFFFF_FFFF);
    rd(0, v); chk("R2 ctrl readback", v, {ID, 24'h9});
    wr(0, 32'h0);
    rd(0, v); chk("R2 ctrl cleared", v, {ID, 24'h0});
  endtask

  task automatic t_cycle;
    logic [31:0] v;
    wr(0, 32'h5); idle(9); wr(0, 32'h0);
    rd(4, v); chk("R3 cycle count", v, 10);
    idle(5);
    rd(4, v); chk("R3 cycle hold", v, 10);
  endtask

  task automatic t_div;
    logic [31:0] v;
    wr(0, 32'hD); idle(126); wr(0, 32'h0);
    rd(4, v); chk("R4 div 127 edges", v, 1);
    wr(0, 32'hD); idle(127); wr(0, 32'h0);
    rd(4, v); chk("R4 div 128 edges", v, 2);
  endtask

  task automatic t_events;
    logic [31:0] v;
    wr(3, 32'hFE20_1005);
    wr(0, 32'h3);
    ev_strobe = '0; ev_strobe[5] = 1'b1; idle(3);
    ev_strobe = '0; ev_strobe[16] = 1'b1; ev_strobe[32] = 1'b1; idle(2);
    ev_strobe = '0; ev_strobe[254] = 1'b1; idle(4);
    ev_strobe = '0; wr(0, 32'h0);
    rd(5, v); chk("R5 ev0", v, 3);
    rd(6, v); chk("R5 ev1", v, 2);
    rd(7, v); chk("R5 ev2", v, 2);
    rd(8, v); chk("R5 ev3", v, 4);
  endtask

  task automatic t_park;
    logic [31:0] v;
    wr(3, 32'h0000_00FF);
    wr(0, 32'h3);
    ev_strobe = '0; ev_strobe[255] = 1'b1; ev_strobe[0] = 1'b1; idle(5);
    ev_strobe = '0; wr(0, 32'h0);
    rd(5, v); chk("R6 parked ev0", v, 0);
    rd(6, v); chk("R6 code0 ev1", v, 5);
  endtask

  task automatic t_load;
    logic [31:0] v;
    wr(6, 32'h1234_5678);
    rd(6, v); chk("R7 load ev1", v, 32'h1234_5678);
    wr(3, 32'h0000_0005);
    wr(0, 32'h1);
    ev_strobe[5] = 1'b1;
    wr(5, 32'd100);
    wr(0, 32'h0);
    ev_strobe = '0;
    rd(5, v); chk("R7 load beats inc", v, 101);
  endtask

  task automatic t_resets;
    logic [31:0] v;
    wr(5, 7); wr(7, 9); wr(4, 11);
    wr(0, 32'h2);
    rd(5, v); chk("R8 ev0 cleared", v, 0);
    rd(7, v); chk("R8 ev2 cleared", v, 0);
    rd(4, v); chk("R8 cycle kept", v, 11);
    rd(0, v); chk("R2 reset bits read 0", v, {ID, 24'h0});
    wr(6, 3);
    wr(0, 32'h4);
    rd(4, v); chk("R8 cycle cleared", v, 0);
    rd(6, v); chk("R8 ev1 kept", v, 3);
  endtask

  task automatic t_wrap;
    logic [31:0] v;
    wr(4, 32'hFFFF_FFFE); wr(0, 32'h1); idle(1); wr(0, 32'h0);
    rd(4, v); chk("R9 cycle wrapped", v, 0);
    rd(1, v); chk("R9 cycle flag", v, 32'h01);
    wr(7, 32'hFFFF_FFFF); wr(3, 32'h0007_0000);
    wr(0, 32'h1); ev_strobe[7] = 1'b1; wr(0, 32'h0); ev_strobe = '0;
    rd(7, v); chk("R9 ev2 wrapped", v, 0);
    rd(1, v); chk("R9 ev2 flag", v, 32'h09);
    wr(1, 32'h01);
    rd(1, v); chk("R9 w1c one bit", v, 32'h08);
    wr(1, 32'h08);
    rd(1, v); chk("R9 w1c rest", v, 32'h00);
  endtask

  task automatic t_prio;
    logic [31:0] v;
    wr(4, 32'hFFFF_FFFF); wr(0, 32'h1);
    wr(1, 32'h01);
    wr(0, 32'h0);
    rd(1, v); chk("R10 set beats clear", v, 32'h01);
  endtask

  task automatic t_irq;
    logic [31:0] v;
    chk("R11 irq no enable", 32'(irq), 0);
    wr(2, 32'h01); #1;
    chk("R11 irq raised", 32'(irq), 1);
    wr(2, 32'hFFFF_FFE2);
    rd(2, v); chk("R11 ien width", v, 32'h02);
    chk("R11 irq other bit", 32'(irq), 0);
    wr(2, 32'h1F); wr(1, 32'h1F); #1;
    chk("R11 irq after clear", 32'(irq), 0);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    idle(3); #1 rst_n = 1'b1; idle(1);
    t_reset; t_ctrl; t_cycle; t_div; t_events; t_park;
    t_load; t_resets; t_wrap; t_prio; t_irq;
    finish_run;
  end

  initial begin
    #(200000 * 8);
    n_run++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run;
  end
endmodule